// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block collects a vector of hardware event lines for a peripheral and turns them into one interrupt request. Each event that goes high for at least one clock sets a pending bit. The bit stays set until software clears it by writing a one to that bit of a write-one-to-clear register. Software reaches the bank through a simple register port: an address, a write strobe, write data and a combinational read-data return.

Software can see three status views. The live view shows the event inputs as they are, with no latching. The sticky view shows every pending bit, whatever the mask says. The masked view shows each pending bit only where its mask bit is one. A single global enable bit gates the registered interrupt output. That bit never stops pending bits from being captured, so software can poll the bank with the line turned off.

Top module: `irq_regbank`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The global enable lives in bit 0 at offset 0x0C and the mask at offset 0x10. Both are written when `wr_en_i` is high at a rising clock edge and read back the value written. The other enable bits read 0.
- R3: An event input that is 1 at a rising edge sets its pending bit, whatever its mask bit. The sticky view at offset 0x1C shows the pending bit, and the bit stays 1 until software clears it.
- R4: The clear register at offset 0x14 clears each pending bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read of offset 0x14 returns 0.
- R5: If an event is 1 in the same cycle that software clears its bit, the bit stays pending.
- R6: Offset 0x20 reads the current event inputs combinationally, with no latching.
- R7: Offset 0x18 reads the pending bits ANDed with the mask. A mask bit of 1 lets its bit through and a mask bit of 0 reads as 0.
- R8: `irq_o` is a register. It equals the global enable ANDed with the OR of all masked pending bits, taken one clock after those values settle.
- R9: While the global enable is 0, `irq_o` stays 0 and events are still captured as pending.
- R10: Writes to offsets 0x18, 0x1C and 0x20 change nothing. An offset that is not mapped reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Hardware event lines, active high |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
A wrong pending bit shows up at offset 0x1C in the cycle after the edge that should have set or cleared it. It also shows at offset 0x18 whenever its mask bit is one. One clock after that, it reaches `irq_o` as a line that is stuck high or missing. A wrong mask or enable value reads back wrong at once, and it shows on `irq_o` two edges after the write. For that reason the interrupt line is sampled exactly one and two cycles after each write, so that an off-by-one pipeline is caught. A write that leaks into a read-only or unmapped offset is caught by reading back the registers it could have touched.

// File: rtl/irq_regbank.sv
module irq_regbank #(
  parameter int NUM_EVT = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_MSTS = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_STKY = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(8'h20);

  logic               en_q;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] sticky_q;
  logic [NUM_EVT-1:0] clr_vec;
  logic [NUM_EVT-1:0] masked;
  logic [NUM_EVT-1:0] keep;

  assign clr_vec = (wr_en_i && addr_i == OFS_CLR) ? wr_data_i[NUM_EVT-1:0] : '0;
  assign masked  = sticky_q & mask_q;
  assign keep    = sticky_q & ~clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mask_q   <= '0;
      sticky_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == OFS_EN)   en_q   <= wr_data_i[0];
      if (wr_en_i && addr_i == OFS_MASK) mask_q <= wr_data_i[NUM_EVT-1:0];
      sticky_q <= keep | evt_i;
      irq_o    <= en_q & (|masked);
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      OFS_EN:   rd_data_o[0]         = en_q;
      OFS_MASK: rd_data_o[NUM_EVT-1:0] = mask_q;
      OFS_MSTS: rd_data_o[NUM_EVT-1:0] = masked;
      OFS_STKY: rd_data_o[NUM_EVT-1:0] = sticky_q;
      OFS_RAW:  rd_data_o[NUM_EVT-1:0] = evt_i;
      default:  rd_data_o = '0;
    endcase
  end

  // Pending bits not being cleared must survive the edge.
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & $past(keep)) == $past(keep)));

  // Any event present at an edge is pending afterwards, clear or not.
  assert_event_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & $past(evt_i)) == $past(evt_i)));

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_o);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(sticky_q & mask_q)));

  always_comb begin
    if (rst_n && addr_i == OFS_CLR)
      assert_clr_reads_zero_R4: assert (rd_data_o == '0);
  end

endmodule

// File: tb/tb_irq_regbank.sv
module tb_irq_regbank;
  localparam int NE = 32;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_regbank #(.NUM_EVT(NE), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [NE-1:0] evt;
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] exp_rd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 1'b0, 8'h0C, 32'h0,        32'h0}, // R1 enable reset
    '{32'h0, 1'b0, 8'h10, 32'h0,        32'h0}, // R1 mask reset
    '{32'h5, 1'b0, 8'h20, 32'h0,        32'h5}, // R6 live view
    '{32'h0, 1'b0, 8'h1C, 32'h0,        32'h5}, // R3 captured while masked
    '{32'h0, 1'b0, 8'h18, 32'h0,        32'h0}, // R7 mask 0 hides
    '{32'h0, 1'b1, 8'h10, 32'h4,        32'h0}, // R2 mask write, old value read
    '{32'h0, 1'b0, 8'h18, 32'h0,        32'h4}, // R7 mask 1 passes
    '{32'h0, 1'b1, 8'h14, 32'h1,        32'h0}, // R4 clear bit0, read 0
    '{32'h0, 1'b0, 8'h1C, 32'h0,        32'h4}, // R4 zeros leave bit2
    '{32'h4, 1'b1, 8'h14, 32'h4,        32'h0}, // R5 set and clear together
    '{32'h0, 1'b0, 8'h1C, 32'h0,        32'h4}, // R5 set wins
    '{32'h0, 1'b1, 8'h1C, 32'hFFFF,     32'h4}, // R10 write to sticky view
    '{32'h0, 1'b0, 8'h1C, 32'h0,        32'h4}, // R10 unchanged
    '{32'h0, 1'b1, 8'h40, 32'hFF,       32'h0}, // R10 unmapped write
    '{32'h0, 1'b0, 8'h40, 32'h0,        32'h0}, // R10 unmapped reads 0
    '{32'h0, 1'b0, 8'h10, 32'h0,        32'h4}, // R10 mask untouched
    '{32'h0, 1'b1, 8'h14, 32'hFFFFFFFF, 32'h0}, // R4 clear all
    '{32'h0, 1'b0, 8'h1C, 32'h0,        32'h0}  // R4 all cleared
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr_i = a; wr_en_i = 1'b0;
    #1 d = rd_data_o;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h1C, v); chk("R1 sticky reset", v, 32'h0);
    rd(8'h18, v); chk("R1 masked reset", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt_i = VECS[i].evt; wr_en_i = VECS[i].wr;
      addr_i = VECS[i].addr; wr_data_i = VECS[i].wdata;
      #4;
      chk($sformatf("vector %0d", i), rd_data_o, VECS[i].exp_rd);
    end
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0;

    // R9: line gated off, capture continues
    wr(8'h10, 32'h2);
    evt_i = 32'h2;
    @(negedge clk); evt_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 irq off while disabled", {31'b0, irq_o}, 32'h0);
    rd(8'h1C, v); chk("R9 captured while disabled", v, 32'h2);

    // R8: two-edge latency from enable write
    wr(8'h0C, 32'h1);
    chk("R8 irq one edge after enable", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R8 irq two edges after enable", {31'b0, irq_o}, 32'h1);
    rd(8'h0C, v); chk("R2 enable readback", v, 32'h1);

    // R8: masking drops line two edges later
    wr(8'h10, 32'h0);
    chk("R8 irq held one edge after mask", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R8 irq drops after mask", {31'b0, irq_o}, 32'h0);
    wr(8'h10, 32'h2);
    @(negedge clk);
    chk("R7 irq back with mask", {31'b0, irq_o}, 32'h1);

    // R4: clear removes cause
    wr(8'h14, 32'h2);
    @(negedge clk);
    chk("R4 irq after clear", {31'b0, irq_o}, 32'h0);
    rd(8'h1C, v); chk("R4 sticky after clear", v, 32'h0);

    // R9: disable while event pending
    wr(8'h0C, 32'h0);
    evt_i = 32'h2;
    @(negedge clk); evt_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 irq stays off", {31'b0, irq_o}, 32'h0);
    rd(8'h18, v); chk("R7 masked pending", v, 32'h2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule